// File: doc/BRIEF.md
# Eight-Pin GPIO Bank with Change Interrupts and Modem Line Sharing

This block is an eight-pin general-purpose I/O bank reached through a small synchronous register port. Each pin can be an input or an output. Every input is resynchronised to the block clock. An input whose enable bit is set can raise an interrupt when its level changes. Change interrupts run in one of two modes. In transparent mode the interrupt stays raised only while the pin differs from the level seen at the last read of the level register. In latched mode the first change is held, together with the level that caused it, until the level register is read.

A mode bit in the control register hands the upper four pins to modem-control duties. In that mode the pins work as ring indicator (pin 7), carrier detect (pin 6), data-terminal-ready output (pin 5) and data-set-ready (pin 4). The three modem inputs feed a modem status register that keeps delta bits. Those delta bits can raise an interrupt through their own enable. The control register also has a self-clearing software reset that returns the whole bank to its power-up state.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0. That covers direction, level, interrupt enable, control, modem control, modem interrupt enable and modem status delta bits. `pin_oe` is 0 and `irq` is 0.
- R2: Register addresses are: 0 direction, 1 level, 2 pin interrupt enable, 3 control, 4 modem control, 5 modem interrupt enable, 6 modem status, 7 reads 0. A write takes effect at the clock edge where `wr_en` is sampled high. `rdata` shows the addressed register combinationally.
- R3: A pin the bank owns with direction bit 1 is an output. `pin_oe` is 1 and `pin_out` carries that bit of the level register, which also reads back from the level register. An output pin never raises a change interrupt.
- R4: Transparent mode (control bit 0 = 0). An enabled input whose level differs from its reference level raises `irq` within 3 cycles, counted through the two-flop synchroniser. If the pin goes back to the reference level before a read, the interrupt drops again.
- R5: Transparent mode. A read of the level register sets each reference level to the current synchronised level, which clears the interrupt. Reading an input bit returns its synchronised level.
- R6: Latched mode (control bit 0 = 1). The first change on an enabled input sets a pending flag and captures the new level. The flag and the captured level persist if the pin returns. Until the next read of the level register, that bit reads back the captured level.
- R7: Latched mode. A read of the level register clears the pending flags, so `irq` falls. Later reads show the live level again.
- R8: Modem mode (control bit 1 = 1). Pins 7, 6 and 4 are inputs. Pin 5 is an output driven by modem control bit 0. So `pin_oe[7:4]` = 4'b0010. Bits 7:4 of the direction, level and enable registers have no effect on these pins.
- R9: The modem status register reads as follows. Bit 7 is carrier detect (pin 6), bit 6 is ring indicator (pin 7) and bit 5 is data-set-ready (pin 4), each at its synchronised level. Bit 3 is the carrier-detect delta, bit 2 is the ring-indicator falling edge, bit 1 is the data-set-ready delta, and bits 4 and 0 are 0. A read clears the delta bits.
- R10: `irq` is the OR of the pin change interrupts and the modem interrupt. The modem interrupt is bit 3 of the modem interrupt enable register ANDed with any modem delta bit.
- R11: In GPIO mode (control bit 1 = 0), modem status reads 0. No delta is recorded, so no modem interrupt arises. Pin 5 does not follow modem control bit 0.
- R12: Writing control with bit 3 set resets every register of the bank on the next cycle. The control bit then reads 0, and control bits 7:4 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; read side effects occur at this edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| pin_in | input | 8 | Pin input levels, asynchronous |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables, 1 = drive |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that `wr_en` and `rd_en` are clean single-cycle strobes applied with a stable address. They also assume that a write to control is the only source of the software reset. Checks that span a cycle boundary are therefore disabled while that reset is pending. The modem-delta property relies on the read strobe seeing a cycle with no new modem edge. The bench holds every pin level for at least four cycles, so the synchroniser and edge detector settle before each interrupt is sampled. It never toggles a pin in the same cycle as a clearing read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NPINS    = 8;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int MODEM_LO = 4;

    // pin roles in modem mode
    localparam int PIN_RI  = 7;
    localparam int PIN_CD  = 6;
    localparam int PIN_DTR = 5;
    localparam int PIN_DSR = 4;

    localparam int IER_MODEM_BIT = 3;
    localparam int MCR_DTR_BIT   = 0;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR   = 3'd0,
        A_LEVEL = 3'd1,
        A_IEN   = 3'd2,
        A_CTRL  = 3'd3,
        A_MCR   = 3'd4,
        A_MIE   = 3'd5,
        A_MSR   = 3'd6,
        A_NONE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [3:0] rsvd_hi;
        logic       swrst;
        logic       rsvd_lo;
        logic       modem_sel;
        logic       latch_en;
    } ctrl_t;

    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
        logic dcd;
        logic teri;
        logic ddsr;
        logic dcts;
    } msr_t;

    typedef struct packed {
        logic dcd;
        logic teri;
        logic ddsr;
    } delta_t;

    // keep only the stored mode bits of a control write
    function automatic ctrl_t ctrl_from_write(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c           = '0;
        c.modem_sel = w[1];
        c.latch_en  = w[0];
        return c;
    endfunction

    function automatic logic pin_owned(input int idx, input logic modem);
        return (idx < MODEM_LO) || !modem;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_prev
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
            q_prev <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            q_prev <= pipe[STAGES-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic lvl_prev,
    input  logic is_input,
    input  logic ien,
    input  logic latch_en,
    input  logic clr,
    output logic pend,
    output logic rd_val
);
    logic ref_lvl;
    logic flag;
    logic cap;
    logic armed;

    assign armed = is_input && ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_lvl <= 1'b0;
            flag    <= 1'b0;
            cap     <= 1'b0;
        end else begin
            // reference follows the pin unless an armed input is watching it
            if (!armed || clr) ref_lvl <= lvl;

            if (!latch_en) begin
                flag <= 1'b0;
            end else if (armed && (lvl != lvl_prev) && !flag) begin
                flag <= 1'b1;
                cap  <= lvl;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

    assign pend   = latch_en ? flag : (armed && (lvl != ref_lvl));
    assign rd_val = flag ? cap : lvl;
endmodule

// File: rtl/gpio_bank_modem.sv
module gpio_bank_modem
    import gpio_bank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   modem_en,
    input  logic   ri,
    input  logic   ri_prev,
    input  logic   cd,
    input  logic   cd_prev,
    input  logic   dsr,
    input  logic   dsr_prev,
    input  logic   clr,
    output msr_t   msr,
    output delta_t delta
);
    delta_t ev;

    always_comb begin
        ev.dcd  = modem_en && (cd != cd_prev);
        ev.teri = modem_en && ri_prev && !ri;
        ev.ddsr = modem_en && (dsr != dsr_prev);
    end

    always_ff @(posedge clk) begin
        if (rst || !modem_en) begin
            delta <= '0;
        end else if (clr) begin
            delta <= ev;
        end else begin
            delta <= delta | ev;
        end
    end

    always_comb begin
        msr      = '0;
        msr.cd   = modem_en && cd;
        msr.ri   = modem_en && ri;
        msr.dsr  = modem_en && dsr;
        msr.dcd  = delta.dcd;
        msr.teri = delta.teri;
        msr.ddsr = delta.ddsr;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    reg_addr_e         a;
    logic              swrst_q;
    logic              ir;
    logic [NPINS-1:0]  dir_q;
    logic [NPINS-1:0]  level_q;
    logic [NPINS-1:0]  ien_q;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] mcr_q;
    logic [DATA_W-1:0] mie_q;
    logic [NPINS-1:0]  sync_cur;
    logic [NPINS-1:0]  sync_prev;
    logic [NPINS-1:0]  gpio_pend;
    logic [NPINS-1:0]  pin_rd;
    logic [NPINS-1:0]  level_rd;
    logic [NPINS-1:0]  is_input;
    logic              modem_en;
    logic              latch_en;
    logic              rd_level;
    logic              rd_msr;
    msr_t              msr;
    delta_t            delta;

    assign a        = reg_addr_e'(addr);
    assign ir       = rst || swrst_q;
    assign modem_en = ctrl_q.modem_sel;
    assign latch_en = ctrl_q.latch_en;
    assign rd_level = rd_en && (a == A_LEVEL);
    assign rd_msr   = rd_en && (a == A_MSR);

    // software reset pulse: one cycle after the control write
    always_ff @(posedge clk) begin
        if (ir) swrst_q <= 1'b0;
        else    swrst_q <= wr_en && (a == A_CTRL) && wdata[3];
    end

    always_ff @(posedge clk) begin
        if (ir) begin
            dir_q   <= '0;
            level_q <= '0;
            ien_q   <= '0;
            ctrl_q  <= '0;
            mcr_q   <= '0;
            mie_q   <= '0;
        end else if (wr_en) begin
            case (a)
                A_DIR:   dir_q   <= wdata;
                A_LEVEL: level_q <= wdata;
                A_IEN:   ien_q   <= wdata;
                A_CTRL:  ctrl_q  <= ctrl_from_write(wdata);
                A_MCR:   mcr_q   <= wdata;
                A_MIE:   mie_q   <= wdata;
                default: ;
            endcase
        end
    end

    gpio_bank_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      (pin_in),
        .q      (sync_cur),
        .q_prev (sync_prev)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic owned;
        assign owned       = pin_owned(i, modem_en);
        assign is_input[i] = owned && !dir_q[i];

        gpio_bank_pin u_pin (
            .clk      (clk),
            .rst      (ir),
            .lvl      (sync_cur[i]),
            .lvl_prev (sync_prev[i]),
            .is_input (is_input[i]),
            .ien      (ien_q[i]),
            .latch_en (latch_en),
            .clr      (rd_level),
            .pend     (gpio_pend[i]),
            .rd_val   (pin_rd[i])
        );

        assign level_rd[i] = is_input[i] ? pin_rd[i] : level_q[i];

        if (i == PIN_DTR) begin : g_dtr
            assign pin_oe[i]  = owned ? dir_q[i] : 1'b1;
            assign pin_out[i] = owned ? level_q[i] : mcr_q[MCR_DTR_BIT];
        end else begin : g_plain
            assign pin_oe[i]  = owned && dir_q[i];
            assign pin_out[i] = owned && level_q[i];
        end
    end

    gpio_bank_modem u_modem (
        .clk      (clk),
        .rst      (ir),
        .modem_en (modem_en),
        .ri       (sync_cur[PIN_RI]),
        .ri_prev  (sync_prev[PIN_RI]),
        .cd       (sync_cur[PIN_CD]),
        .cd_prev  (sync_prev[PIN_CD]),
        .dsr      (sync_cur[PIN_DSR]),
        .dsr_prev (sync_prev[PIN_DSR]),
        .clr      (rd_msr),
        .msr      (msr),
        .delta    (delta)
    );

    always_comb begin
        unique case (a)
            A_DIR:   rdata = dir_q;
            A_LEVEL: rdata = level_rd;
            A_IEN:   rdata = ien_q;
            A_CTRL:  rdata = ctrl_q;
            A_MCR:   rdata = mcr_q;
            A_MIE:   rdata = mie_q;
            A_MSR:   rdata = msr;
            default: rdata = '0;
        endcase
    end

    assign irq = (|gpio_pend) || (mie_q[IER_MODEM_BIT] && (|delta));
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              swrst_q,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              modem_en,
    input logic              latch_en,
    input logic [DATA_W-1:0] mcr_q,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  gpio_pend,
    input logic [2:0]        delta,
    input logic [NPINS-1:0]  sync_cur,
    input logic [NPINS-1:0]  sync_prev
);
    // R3: a direction write shows up on the low-nibble enables next cycle
    p_dir_oe_r3: assert property (@(posedge clk) disable iff (rst || swrst_q)
        (wr_en && addr == 3'd0) |=> (pin_oe[3:0] == $past(wdata[3:0])));

    // R8: in modem mode only the DTR pin of the upper nibble drives, from MCR bit 0
    p_modem_pins_r8: assert property (@(posedge clk) disable iff (rst)
        modem_en |-> (pin_oe[7:4] == 4'b0010 && pin_out[5] == mcr_q[0]));

    // R12: soft reset brings direction back to zero two edges after the write
    p_swrst_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd3 && wdata[3] && !swrst_q) |=> ##1 (dir_q == '0 && !modem_en && !latch_en));

    // R6: a latched pending change persists until a level read
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst || swrst_q)
        (latch_en && (|gpio_pend) && !(rd_en && addr == 3'd1) && !(wr_en && addr == 3'd3))
        |=> (|gpio_pend));

    // R9: a status read with no modem edge in that cycle leaves no delta
    p_msr_clear_r9: assert property (@(posedge clk) disable iff (rst || swrst_q)
        (rd_en && addr == 3'd6 && sync_cur[7:4] == sync_prev[7:4]) |=> (delta == 3'b000));

    // R11: no delta survives a cycle spent in GPIO mode
    p_gpio_no_delta_r11: assert property (@(posedge clk) disable iff (rst)
        !modem_en |=> (delta == 3'b000));
endmodule

bind gpio_bank gpio_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .swrst_q   (swrst_q),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .modem_en  (modem_en),
    .latch_en  (latch_en),
    .mcr_q     (mcr_q),
    .dir_q     (dir_q),
    .gpio_pend (gpio_pend),
    .delta     (delta),
    .sync_cur  (sync_cur),
    .sync_prev (sync_prev)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    gpio_bank u_dut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq     (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // driver: queue the expected value, then strobe the read
    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        item_t it;
        it.exp = exp;
        it.req = req;
        sb.push_back(it);
        @(posedge clk); #1;
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: compares read data against the scoreboard away from the edge
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en) begin
                if (sb.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R2 actual=%h expected=<none>", rdata);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(it.req, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst = 1'b0;
        settle(1);
        // R1 reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd(3'd0, 8'h00, "R1 dir");
        rd(3'd3, 8'h00, "R1 ctrl");
        rd(3'd6, 8'h00, "R1 msr");
        rd(3'd7, 8'h00, "R2 unused addr");

        // R2/R3 outputs on the low nibble
        wr(3'd0, 8'h0F);
        wr(3'd1, 8'h05);
        rd(3'd0, 8'h0F, "R2 dir readback");
        settle(1);
        check("R3 oe", pin_oe, 8'h0F);
        check("R3 pin_out", pin_out, 8'h05);

        // R3: output pin 0 enabled but never interrupts
        wr(3'd2, 8'hF1);
        pin_in[0] = 1'b1;
        settle(4);
        check("R3 output no irq", {7'd0, irq}, 8'h00);
        pin_in[0] = 1'b0;
        settle(4);

        // R4 transparent: rise raises, return drops
        pin_in[4] = 1'b1;
        settle(4);
        check("R4 irq on change", {7'd0, irq}, 8'h01);
        pin_in[4] = 1'b0;
        settle(4);
        check("R4 irq drops on return", {7'd0, irq}, 8'h00);
        pin_in[4] = 1'b1;
        settle(4);
        check("R4 irq again", {7'd0, irq}, 8'h01);
        // R5 read clears, live level readback
        rd(3'd1, 8'h15, "R5 level read");
        settle(2);
        check("R5 irq cleared", {7'd0, irq}, 8'h00);

        // R6/R7 latched
        wr(3'd3, 8'h01);
        pin_in[5] = 1'b1;
        settle(4);
        pin_in[5] = 1'b0;
        settle(4);
        check("R6 irq held after return", {7'd0, irq}, 8'h01);
        rd(3'd1, 8'h35, "R6 captured level");
        settle(2);
        check("R7 irq cleared", {7'd0, irq}, 8'h00);
        rd(3'd1, 8'h15, "R7 live level");

        // R8 modem pins
        wr(3'd3, 8'h02);
        settle(1);
        check("R8 oe", pin_oe, 8'h2F);
        wr(3'd4, 8'h01);
        settle(1);
        check("R8 dtr high", pin_out, 8'h25);
        wr(3'd4, 8'h00);
        settle(1);
        check("R8 dtr low", pin_out, 8'h05);

        // R9/R10 modem status and interrupt
        wr(3'd5, 8'h08);
        rd(3'd6, 8'h20, "R9 dsr status");
        settle(2);
        check("R8 upper enables ignored", {7'd0, irq}, 8'h00);
        pin_in[6] = 1'b1;
        settle(4);
        check("R10 modem irq on cd", {7'd0, irq}, 8'h01);
        rd(3'd6, 8'hA8, "R9 cd delta");
        settle(2);
        check("R9 read clears delta", {7'd0, irq}, 8'h00);
        pin_in[7] = 1'b1;
        settle(4);
        check("R9 ri rise no delta", {7'd0, irq}, 8'h00);
        pin_in[7] = 1'b0;
        settle(4);
        check("R10 irq on ri fall", {7'd0, irq}, 8'h01);
        rd(3'd6, 8'hA4, "R9 ri trailing edge");
        pin_in[4] = 1'b0;
        settle(4);
        rd(3'd6, 8'h82, "R9 dsr delta");

        // R11 GPIO mode
        wr(3'd2, 8'h01);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h01);
        settle(1);
        check("R11 no dtr in gpio mode", pin_out, 8'h05);
        pin_in[6] = 1'b0;
        settle(4);
        check("R11 no modem irq", {7'd0, irq}, 8'h00);
        rd(3'd6, 8'h00, "R11 msr zero");

        // R12 soft reset
        wr(3'd3, 8'h0B);
        settle(1);
        rd(3'd3, 8'h00, "R12 ctrl cleared");
        rd(3'd0, 8'h00, "R12 dir cleared");
        rd(3'd4, 8'h00, "R12 mcr cleared");
        check("R12 oe", pin_oe, 8'h00);

        settle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule